// File: doc/BRIEF.md
# Interrupt Status Flags with Attribute-Filtered Write-One-To-Clear

This block keeps the interrupt status of a seven-channel DMA controller. Every channel has three event flags (transfer done, half transfer, transfer error) and a summary flag that is raised with any of them. The channel engines raise flags with single-cycle set pulses. Software drops flags by writing ones to a write-only clear word at offset 0x04. Each channel drives one interrupt line, built from its flags and three per-event enable inputs.

Every bus write carries two attributes: secure or non-secure, and privileged or unprivileged. Every channel carries two mode bits with the same meaning. A clear request for a channel acts only when the access is allowed to touch that channel under both rules. A request that fails either rule is dropped without a response. The summary flag follows a fixed rule. A summary clear removes all four flags of the channel. An event clear removes the summary flag only if no other event flag of that channel stays set.

Top module: `ifc_status_clear`

## Requirements
- R1: After synchronous reset every status bit and every interrupt line is 0.
- R2: A write has no effect unless `wr_en` is 1 and `wr_addr` equals 0x04.
- R3: Bits 31:28 of the clear word are reserved. Writing ones to them changes no flag.
- R4: A 0 in any clear bit leaves the matching flag unchanged.
- R5: Channel x (x = 1..7) uses clear bits [4(x-1)+3 : 4(x-1)]. From the low bit up these are: summary, done, half, error. A 1 in the summary clear bit removes the summary flag and all three event flags of that channel.
- R6: A 1 in an event clear bit removes that event flag. It also removes the summary flag, but only if no other event flag of that channel stays set after the write.
- R7: A non-secure access (`acc_secure`=0) cannot change any flag of a channel whose `ch_secure` bit is 1. A secure access may clear any channel.
- R8: An unprivileged access (`acc_priv`=0) cannot change any flag of a channel whose `ch_priv` bit is 1. A privileged access may clear any channel.
- R9: A set pulse raises the matching event flag and the summary flag one cycle later. It wins over a clear of the same flag in the same cycle.
- R10: `irq[x-1]` = summary AND ((done AND en_done) OR (half AND en_half) OR (error AND en_err)), all for channel x.
- R11: `status` uses the same bit layout as the clear word: summary at bit 4(x-1), done at +1, half at +2, error at +3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Write data, ones request clears |
| acc_secure | input | 1 | Access is secure |
| acc_priv | input | 1 | Access is privileged |
| ch_secure | input | 7 | Per-channel secure mode bit |
| ch_priv | input | 7 | Per-channel privileged mode bit |
| set_done | input | 7 | Transfer-done set pulses |
| set_half | input | 7 | Half-transfer set pulses |
| set_err | input | 7 | Transfer-error set pulses |
| en_done | input | 7 | Transfer-done interrupt enables |
| en_half | input | 7 | Half-transfer interrupt enables |
| en_err | input | 7 | Transfer-error interrupt enables |
| status | output | 28 | Flag vector, four bits per channel |
| irq | output | 7 | Per-channel interrupt lines |

## Verification
The bench targets these cases:
- An event clear while a sibling flag is still set. A design that drops the summary flag there would silence an interrupt that is still owed.
- A set and a clear on the same flag in one cycle. A design that lets the clear win would lose that event.
- Writes that fail only the secure rule, or only the privilege rule. A design that checks just one attribute would let a lower-trust master wipe protected status.
- Writes to the reserved bits, writes to the wrong offset, and all-zero writes. A loose decoder would clear flags there, or clear a neighbouring channel.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

    localparam int FLD_W = 4;

    // Bit order inside one channel field; bit 0 is the summary flag.
    typedef struct packed {
        logic err;
        logic half;
        logic done;
        logic summ;
    } ch_flags_t;

    typedef struct packed {
        logic err;
        logic half;
        logic done;
    } ch_evt_t;

    function automatic logic access_allowed(
        input logic acc_sec,
        input logic acc_prv,
        input logic ch_sec,
        input logic ch_prv
    );
        return (acc_sec | ~ch_sec) & (acc_prv | ~ch_prv);
    endfunction

endpackage

// File: rtl/ifc_access_filter.sv
module ifc_access_filter #(
    parameter int N_CH = 7
) (
    input  logic            acc_secure,
    input  logic            acc_priv,
    input  logic [N_CH-1:0] ch_secure,
    input  logic [N_CH-1:0] ch_priv,
    output logic [N_CH-1:0] grant
);
    import ifc_pkg::*;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign grant[c] = access_allowed(acc_secure, acc_priv, ch_secure[c], ch_priv[c]);
    end

endmodule

// File: rtl/ifc_clear_decode.sv
module ifc_clear_decode #(
    parameter int          N_CH       = 7,
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 8,
    parameter logic [7:0]  CLR_OFFSET = 8'h04
) (
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic [N_CH-1:0]             grant,
    output ifc_pkg::ch_flags_t [N_CH-1:0] clr
);
    import ifc_pkg::*;

    localparam int USED_W = N_CH * FLD_W;

    logic hit;
    logic unused_rsvd;

    assign hit         = wr_en && (wr_addr == ADDR_W'(CLR_OFFSET));
    assign unused_rsvd = ^wr_data[DATA_W-1:USED_W];

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        assign clr[c] = (hit && grant[c]) ? ch_flags_t'(wr_data[c*FLD_W +: FLD_W])
                                          : ch_flags_t'('0);
    end

endmodule

// File: rtl/ifc_flag_cell.sv
module ifc_flag_cell (
    input  logic               clk,
    input  logic               rst,
    input  ifc_pkg::ch_evt_t   set,
    input  ifc_pkg::ch_flags_t clr,
    input  ifc_pkg::ch_evt_t   en,
    output ifc_pkg::ch_flags_t flags,
    output logic               irq
);
    import ifc_pkg::*;

    ch_evt_t   kept;
    ch_flags_t nxt;
    logic      evt_clr;
    logic      summ_keep;

    always_comb begin
        kept.done = flags.done & ~(clr.done | clr.summ);
        kept.half = flags.half & ~(clr.half | clr.summ);
        kept.err  = flags.err  & ~(clr.err  | clr.summ);
        evt_clr   = clr.done | clr.half | clr.err;
        summ_keep = flags.summ & ~clr.summ
                  & ~(evt_clr & ~(kept.done | kept.half | kept.err));
        nxt.done  = kept.done | set.done;
        nxt.half  = kept.half | set.half;
        nxt.err   = kept.err  | set.err;
        nxt.summ  = summ_keep | set.done | set.half | set.err;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= nxt;
    end

    assign irq = flags.summ & ((flags.done & en.done) |
                               (flags.half & en.half) |
                               (flags.err  & en.err));

endmodule

// File: rtl/ifc_status_clear.sv
module ifc_status_clear #(
    parameter int          N_CH       = 7,
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 8,
    parameter logic [7:0]  CLR_OFFSET = 8'h04,
    localparam int         STAT_W     = N_CH * ifc_pkg::FLD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              acc_secure,
    input  logic              acc_priv,
    input  logic [N_CH-1:0]   ch_secure,
    input  logic [N_CH-1:0]   ch_priv,
    input  logic [N_CH-1:0]   set_done,
    input  logic [N_CH-1:0]   set_half,
    input  logic [N_CH-1:0]   set_err,
    input  logic [N_CH-1:0]   en_done,
    input  logic [N_CH-1:0]   en_half,
    input  logic [N_CH-1:0]   en_err,
    output logic [STAT_W-1:0] status,
    output logic [N_CH-1:0]   irq
);
    import ifc_pkg::*;

    logic [N_CH-1:0]        grant;
    ch_flags_t [N_CH-1:0]   clr;
    ch_flags_t [N_CH-1:0]   flags;

    ifc_access_filter #(.N_CH(N_CH)) u_filter (
        .acc_secure (acc_secure),
        .acc_priv   (acc_priv),
        .ch_secure  (ch_secure),
        .ch_priv    (ch_priv),
        .grant      (grant)
    );

    ifc_clear_decode #(
        .N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLR_OFFSET(CLR_OFFSET)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .grant   (grant),
        .clr     (clr)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_cell
        ch_evt_t set_c, en_c;
        assign set_c = '{err: set_err[c], half: set_half[c], done: set_done[c]};
        assign en_c  = '{err: en_err[c],  half: en_half[c],  done: en_done[c]};

        ifc_flag_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .set   (set_c),
            .clr   (clr[c]),
            .en    (en_c),
            .flags (flags[c]),
            .irq   (irq[c])
        );
    end

    assign status = flags;

endmodule

// File: rtl/ifc_status_clear_chk.sv
module ifc_status_clear_chk #(
    parameter int          N_CH       = 7,
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 8,
    parameter logic [7:0]  CLR_OFFSET = 8'h04,
    localparam int         STAT_W     = N_CH * 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              acc_secure,
    input logic              acc_priv,
    input logic [N_CH-1:0]   ch_secure,
    input logic [N_CH-1:0]   ch_priv,
    input logic [N_CH-1:0]   set_done,
    input logic [N_CH-1:0]   set_half,
    input logic [N_CH-1:0]   set_err,
    input logic [N_CH-1:0]   en_done,
    input logic [N_CH-1:0]   en_half,
    input logic [N_CH-1:0]   en_err,
    input logic [STAT_W-1:0] status,
    input logic [N_CH-1:0]   irq
);
    logic wr_hit;
    assign wr_hit = wr_en && (wr_addr == ADDR_W'(CLR_OFFSET));

    for (genvar c = 0; c < N_CH; c++) begin : g_chk
        logic any_set;
        logic permit;
        assign any_set = set_done[c] | set_half[c] | set_err[c];
        assign permit  = (acc_secure | ~ch_secure[c]) & (acc_priv | ~ch_priv[c]);

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_done[c] |=> (status[4*c+1] && status[4*c])); // R9

        AST_SEC_DENY: assert property (@(posedge clk) disable iff (rst)
            (wr_hit && !acc_secure && ch_secure[c] && !any_set)
            |=> $stable(status[4*c +: 4])); // R7

        AST_PRIV_DENY: assert property (@(posedge clk) disable iff (rst)
            (wr_hit && !acc_priv && ch_priv[c] && !any_set)
            |=> $stable(status[4*c +: 4])); // R8

        AST_GLOBAL_CLR: assert property (@(posedge clk) disable iff (rst)
            (wr_hit && permit && wr_data[4*c] && !any_set)
            |=> (status[4*c +: 4] == 4'h0)); // R5

        AST_IRQ_NEEDS_SUMM: assert property (@(posedge clk) disable iff (rst)
            irq[c] |-> status[4*c]); // R10
    end

    AST_ZERO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data == '0 && set_done == '0 && set_half == '0 && set_err == '0)
        |=> $stable(status)); // R4

endmodule

bind ifc_status_clear ifc_status_clear_chk #(
    .N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CLR_OFFSET(CLR_OFFSET)
) u_chk (.*);

// File: tb/test_ifc_status_clear.sv
module test_ifc_status_clear;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h04;
    logic [31:0] wr_data = '0;
    logic        acc_secure = 1'b1, acc_priv = 1'b1;
    logic [6:0]  ch_secure = '0, ch_priv = '0;
    logic [6:0]  set_done = '0, set_half = '0, set_err = '0;
    logic [6:0]  en_done = '0, en_half = '0, en_err = '0;
    logic [27:0] status;
    logic [6:0]  irq;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    logic [27:0] model = '0;
    logic [27:0] prev;
    int unsigned seed_sink;

    always #10 clk = ~clk;

    ifc_status_clear i_ifc_status_clear (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .acc_secure(acc_secure), .acc_priv(acc_priv),
        .ch_secure(ch_secure), .ch_priv(ch_priv),
        .set_done(set_done), .set_half(set_half), .set_err(set_err),
        .en_done(en_done), .en_half(en_half), .en_err(en_err),
        .status(status), .irq(irq)
    );

    function automatic logic [27:0] next_model(input logic [27:0] s);
        logic [27:0] n;
        n = s;
        for (int c = 0; c < 7; c++) begin
            logic ok, g, d, h, e, cg, cd, ch, ce;
            ok = wr_en && (wr_addr == 8'h04) && (acc_secure || !ch_secure[c])
                 && (acc_priv || !ch_priv[c]);
            g = s[4*c]; d = s[4*c+1]; h = s[4*c+2]; e = s[4*c+3];
            cg = ok & wr_data[4*c];   cd = ok & wr_data[4*c+1];
            ch = ok & wr_data[4*c+2]; ce = ok & wr_data[4*c+3];
            if (cg) begin g = 0; d = 0; h = 0; e = 0; end
            if (cd) d = 0;
            if (ch) h = 0;
            if (ce) e = 0;
            if ((cd || ch || ce) && !d && !h && !e) g = 0;
            if (set_done[c]) begin d = 1; g = 1; end
            if (set_half[c]) begin h = 1; g = 1; end
            if (set_err[c])  begin e = 1; g = 1; end
            n[4*c +: 4] = {e, h, d, g};
        end
        return n;
    endfunction

    function automatic logic [6:0] model_irq(input logic [27:0] s);
        logic [6:0] r;
        for (int c = 0; c < 7; c++)
            r[c] = s[4*c] & ((s[4*c+1] & en_done[c]) | (s[4*c+2] & en_half[c]) |
                             (s[4*c+3] & en_err[c]));
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a falling edge with inputs set up; returns one cycle later.
    task automatic tick(input string tag);
        model = next_model(model);
        @(negedge clk);
        check({tag, " status (R11)"}, {4'h0, status}, {4'h0, model});
        check({tag, " irq (R10)"}, {25'h0, irq}, {25'h0, model_irq(model)});
        wr_en = 0; wr_addr = 8'h04; wr_data = '0;
        set_done = '0; set_half = '0; set_err = '0;
    endtask

    task automatic clr_write(input logic [31:0] d);
        wr_en = 1; wr_addr = 8'h04; wr_data = d;
    endtask

    initial begin
        seed_sink = $urandom(32'd715);
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1 status after reset", {4'h0, status}, 32'h0);
        check("R1 irq after reset", {25'h0, irq}, 32'h0);

        set_done = 7'h7F; tick("R9 set all done");
        check("R11 layout done+summary", {4'h0, status}, 32'h3333333);
        set_half[0] = 1; tick("R9 half ch1");
        clr_write(32'h2); tick("R6 clear done sibling set");
        check("R6 summary kept", {28'h0, status[3:0]}, 32'h5);
        clr_write(32'h4); tick("R6 clear last event");
        check("R6 summary dropped", {28'h0, status[3:0]}, 32'h0);
        clr_write(32'h10); tick("R5 summary clear ch2");
        check("R5 ch2 zero", {28'h0, status[7:4]}, 32'h0);

        prev = status;
        clr_write(32'hF000_0000); tick("R3 reserved bits");
        check("R3 unchanged", {4'h0, status}, {4'h0, prev});
        clr_write(32'h0); tick("R4 zero write");
        check("R4 unchanged", {4'h0, status}, {4'h0, prev});
        wr_en = 1; wr_addr = 8'h08; wr_data = 32'h0FFF_FFFF; tick("R2 wrong offset");
        check("R2 unchanged offset", {4'h0, status}, {4'h0, prev});
        wr_en = 0; wr_addr = 8'h04; wr_data = 32'h0FFF_FFFF; tick("R2 no strobe");
        check("R2 unchanged strobe", {4'h0, status}, {4'h0, prev});

        ch_secure = 7'b0000100; acc_secure = 0;
        clr_write(32'h100); tick("R7 non-secure denied");
        check("R7 ch3 kept", {28'h0, status[11:8]}, 32'h3);
        acc_secure = 1; clr_write(32'h100); tick("R7 secure allowed");
        check("R7 ch3 cleared", {28'h0, status[11:8]}, 32'h0);

        ch_priv = 7'b0001000; acc_priv = 0;
        clr_write(32'h1000); tick("R8 unprivileged denied");
        check("R8 ch4 kept", {28'h0, status[15:12]}, 32'h3);
        acc_priv = 1; clr_write(32'h1000); tick("R8 privileged allowed");
        check("R8 ch4 cleared", {28'h0, status[15:12]}, 32'h0);

        set_done[4] = 1; clr_write(32'h2_0000); tick("R9 set beats clear");
        check("R9 ch5 kept", {28'h0, status[19:16]}, 32'h3);
        en_done[4] = 1; tick("R10 enable on");
        check("R10 irq ch5 high", {31'h0, irq[4]}, 32'h1);
        en_done[4] = 0; tick("R10 enable off");
        check("R10 irq ch5 low", {31'h0, irq[4]}, 32'h0);

        for (int i = 0; i < 4000; i++) begin
            wr_en      = $urandom_range(0, 1);
            wr_addr    = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'h04;
            wr_data    = $urandom;
            acc_secure = $urandom_range(0, 1);
            acc_priv   = $urandom_range(0, 1);
            ch_secure  = 7'($urandom);
            ch_priv    = 7'($urandom);
            set_done   = 7'($urandom & $urandom & $urandom);
            set_half   = 7'($urandom & $urandom & $urandom);
            set_err    = 7'($urandom & $urandom & $urandom);
            en_done    = 7'($urandom);
            en_half    = 7'($urandom);
            en_err     = 7'($urandom);
            tick("R5 R6 R7 R8 R9 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule